// File: doc/BRIEF.md
# WISHBONE Master with Retry Backoff

This block is one bus-facing master port of a memory-to-memory transfer engine. A sequencer hands it one transaction at a time. The transaction gives a start address, a beat count, a direction and a byte select. The port then runs either a single classic cycle or an incrementing burst on a WISHBONE B.3 bus. Data moves one beat at a time. Write data comes from the sequencer on `wr_data`. Read data goes back on `rd_data`, with `beat_ack` marking each accepted beat.

The port acts on every way a slave can end a beat:
- An acknowledge advances the transfer.
- An error aborts the whole transaction and raises a one-cycle fault pulse.
- A retry drops the bus cycle at once. The port then waits a fixed backoff of `RETRY_WAIT` clocks and reopens the cycle at the beat that was refused, with only the beats that are still outstanding.

The cycle-type code marks classic cycles, burst beats and the closing beat of a burst. The burst-type extension and the lock output stay at zero.

Top module: `wbm_retry_port`

## Requirements
- R1: After a synchronous active-low reset, every bus output is 0, no cycle is open, `req_ready` is 1 and both `done_o` and `fault_o` are 0.
- R2: A request is taken when `req_valid` and `req_ready` are both high.
  - In the next cycle `wb_cyc_o` and `wb_stb_o` rise together.
  - `wb_adr_o` then carries the start address, `wb_we_o` the direction (1 = write) and `wb_sel_o` the byte select.
  - `req_ready` stays low until the transaction ends.
  - A `req_valid` seen while the port is busy, including during a backoff, is ignored.
- R3: A beat count of 1 gives a classic cycle with `wb_cti_o` = 000. The acknowledge closes it: `wb_cyc_o` is low in the next cycle and `done_o` pulses high for exactly that one cycle.
- R4: A beat count of 4, 8, 16, 32 or 64 gives an incrementing burst.
  - `wb_cti_o` is 010 on every beat except the last, which carries 111.
  - The address steps by DW/8 bytes (4 by default) after each acknowledged beat.
  - `wb_cyc_o` stays high from the first beat until the last beat is acknowledged.
- R5: `beat_ack` is high in exactly those cycles where an open cycle gets an acknowledge with neither error nor retry. During a read, `rd_data` equals `wb_dat_i`. During a write, `wb_dat_o` equals `wr_data`.
- R6: A retry on an open cycle drops `wb_cyc_o` and `wb_stb_o` in the next cycle. Both stay low for exactly `RETRY_WAIT` clocks and then rise again. The refused beat is not counted.
- R7: A restarted transaction begins at the address of the refused beat and runs only the beats not yet acknowledged. Its cycle-type codes follow R4 over the remaining beats, so a burst refused on its last beat restarts as one beat coded 111.
- R8: An error on an open cycle drops `wb_cyc_o` in the next cycle, pulses `fault_o` for one cycle, raises no `done_o` and does not retry. The port then returns to idle.
- R9: When several responses arrive together, the error wins over the retry, and the retry wins over the acknowledge.
- R10: `wb_bte_o` is always 00 and `wb_lock_o` is always 0.
- R11: `RETRY_WAIT` is a parameter limited to 1..255 with a default of 16; the default instance waits 16 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Sequencer offers a transaction |
| req_ready | output | 1 | Port is idle and takes a transaction |
| req_addr | input | AW | Start byte address |
| req_beats | input | CNTW | Beat count: 1 classic, 4/8/16/32/64 burst |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | DW/8 | Byte select for every beat |
| wr_data | input | DW | Write data for the current beat |
| beat_ack | output | 1 | Current beat accepted by the slave |
| rd_data | output | DW | Read data for the current beat |
| done_o | output | 1 | One-cycle pulse: transaction finished |
| fault_o | output | 1 | One-cycle pulse: transaction aborted by error |
| wb_adr_o | output | AW | Bus address |
| wb_dat_o | output | DW | Bus write data |
| wb_dat_i | input | DW | Bus read data |
| wb_we_o | output | 1 | Bus write enable |
| wb_sel_o | output | DW/8 | Bus byte select |
| wb_stb_o | output | 1 | Bus strobe |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_cti_o | output | 3 | Cycle type identifier |
| wb_bte_o | output | 2 | Burst type extension, fixed 00 |
| wb_lock_o | output | 1 | Lock, fixed 0 |
| wb_ack_i | input | 1 | Slave acknowledge |
| wb_err_i | input | 1 | Slave error |
| wb_rty_i | input | 1 | Slave retry |

## Verification
The assertions check, on every cycle, how each kind of termination is followed:
- A retry closes the cycle and keeps the beat position and remaining count.
- An error closes the cycle with a fault and no done.
- A non-final burst acknowledge keeps the cycle open and steps the address.
- A final acknowledge closes the cycle with a done pulse.

Only the bench's scenarios show the rest:
- The exact length of the backoff window.
- That a restarted burst carries the right addresses and closing code.
- That requests offered during a backoff have no effect.
- How simultaneous responses are resolved across whole transactions.

// File: rtl/wbm_retry_pkg.sv
// Shared types for the retrying WISHBONE master port.
// Assumes: nothing beyond IEEE 1800-2017.
package wbm_retry_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_WAIT = 2'd2
    } wbm_state_e;

    localparam logic [2:0] CTI_CLASSIC = 3'b000;
    localparam logic [2:0] CTI_INCR    = 3'b010;
    localparam logic [2:0] CTI_END     = 3'b111;

    localparam int unsigned WAIT_MAX = 255;

endpackage

// File: rtl/wbm_beat_track.sv
// Holds the current beat address and the count of beats still owed.
// Assumes: load and advance never coincide; advance only while beats remain.
module wbm_beat_track #(
    parameter int unsigned AW   = 32,
    parameter int unsigned CNTW = 7,
    parameter int unsigned STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [AW-1:0]   ld_addr,
    input  logic [CNTW-1:0] ld_beats,
    input  logic            advance,
    output logic [AW-1:0]   cur_addr,
    output logic [CNTW-1:0] remaining,
    output logic            last
);
    localparam logic [AW-1:0]   STEP_V = AW'(STEP);
    localparam logic [CNTW-1:0] ONE    = CNTW'(1);

    logic [AW-1:0]   addr_q;
    logic [CNTW-1:0] left_q;

    // Load a new transaction or step past an acknowledged beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
        end else if (load) begin
            addr_q <= ld_addr;
            left_q <= ld_beats;
        end else if (advance) begin
            addr_q <= addr_q + STEP_V;
            left_q <= left_q - ONE;
        end
    end

    assign cur_addr  = addr_q;
    assign remaining = left_q;
    assign last      = (left_q == ONE);

    // An accepted beat must always have a beat left to account for.
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (left_q != '0));

endmodule

// File: rtl/wbm_backoff_timer.sv
// Counts the idle gap after a retry; expire marks the last waiting clock.
// Assumes: WAIT is within 1..255; start is a single-cycle pulse.
module wbm_backoff_timer #(
    parameter int unsigned WAIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expire
);
    localparam int unsigned TW     = 8;
    localparam logic [TW-1:0] LOAD = TW'(WAIT);

    logic [TW-1:0] cnt_q;

    // Reload on a retry, count down while the port waits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= LOAD;
        else if (run && cnt_q != TW'(1))
            cnt_q <= cnt_q - TW'(1);
    end

    assign expire = run && (cnt_q == TW'(1));

    // The parameter must describe a usable wait.
    initial begin
        assert_wait_range_R11: assert (WAIT >= 1 && WAIT <= wbm_retry_pkg::WAIT_MAX);
    end

endmodule

// File: rtl/wbm_cti_gen.sv
// Encodes the cycle type for the beat now on the bus.
// Assumes: last is valid whenever active is high.
module wbm_cti_gen (
    input  logic       active,
    input  logic       burst,
    input  logic       last,
    output logic [2:0] cti
);
    import wbm_retry_pkg::*;

    // Classic outside bursts; burst beats end with the closing code.
    always_comb begin
        if (!active)
            cti = CTI_CLASSIC;
        else if (!burst)
            cti = CTI_CLASSIC;
        else if (last)
            cti = CTI_END;
        else
            cti = CTI_INCR;
    end

endmodule

// File: rtl/wbm_retry_port.sv
// WISHBONE master port running classic or incrementing-burst transactions
// for a sequencer; restarts refused beats after a fixed backoff.
// Assumes: req_beats is 1, 4, 8, 16, 32 or 64; addresses are aligned to DW/8.
module wbm_retry_port #(
    parameter int unsigned AW         = 32,
    parameter int unsigned DW         = 32,
    parameter int unsigned MAX_BEATS  = 64,
    parameter int unsigned RETRY_WAIT = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [AW-1:0]             req_addr,
    input  logic [$clog2(MAX_BEATS+1)-1:0] req_beats,
    input  logic                      req_write,
    input  logic [DW/8-1:0]           req_sel,
    input  logic [DW-1:0]             wr_data,
    output logic                      beat_ack,
    output logic [DW-1:0]             rd_data,
    output logic                      done_o,
    output logic                      fault_o,
    output logic [AW-1:0]             wb_adr_o,
    output logic [DW-1:0]             wb_dat_o,
    input  logic [DW-1:0]             wb_dat_i,
    output logic                      wb_we_o,
    output logic [DW/8-1:0]           wb_sel_o,
    output logic                      wb_stb_o,
    output logic                      wb_cyc_o,
    output logic [2:0]                wb_cti_o,
    output logic [1:0]                wb_bte_o,
    output logic                      wb_lock_o,
    input  logic                      wb_ack_i,
    input  logic                      wb_err_i,
    input  logic                      wb_rty_i
);
    import wbm_retry_pkg::*;

    localparam int unsigned CNTW = $clog2(MAX_BEATS + 1);
    localparam int unsigned SW   = DW / 8;
    localparam logic [AW-1:0] STEP_V = AW'(SW);

    wbm_state_e      state_q;
    logic            burst_q;
    logic            we_q;
    logic [SW-1:0]   sel_q;
    logic            done_q;
    logic            fault_q;

    logic            in_bus;
    logic            accept;
    logic            resp_ack;
    logic            resp_err;
    logic            resp_rty;
    logic            expire;
    logic [AW-1:0]   cur_addr;
    logic [CNTW-1:0] remaining;
    logic            last;
    logic [2:0]      cti;

    assign in_bus   = (state_q == ST_BUS);
    assign accept   = (state_q == ST_IDLE) && req_valid;

    // Resolve simultaneous responses: error, then retry, then acknowledge.
    always_comb begin
        resp_err = in_bus && wb_err_i;
        resp_rty = in_bus && wb_rty_i && !wb_err_i;
        resp_ack = in_bus && wb_ack_i && !wb_err_i && !wb_rty_i;
    end

    wbm_beat_track #(.AW(AW), .CNTW(CNTW), .STEP(SW)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .ld_addr   (req_addr),
        .ld_beats  (req_beats),
        .advance   (resp_ack),
        .cur_addr  (cur_addr),
        .remaining (remaining),
        .last      (last)
    );

    wbm_backoff_timer #(.WAIT(RETRY_WAIT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (resp_rty),
        .run    (state_q == ST_WAIT),
        .expire (expire)
    );

    wbm_cti_gen u_cti (
        .active (in_bus),
        .burst  (burst_q),
        .last   (last),
        .cti    (cti)
    );

    // Sequence idle, open cycle and backoff wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) state_q <= ST_BUS;
                ST_BUS: begin
                    if (resp_err)               state_q <= ST_IDLE;
                    else if (resp_rty)          state_q <= ST_WAIT;
                    else if (resp_ack && last)  state_q <= ST_IDLE;
                end
                ST_WAIT: if (expire) state_q <= ST_BUS;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Latch the per-transaction attributes when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_q <= 1'b0;
            we_q    <= 1'b0;
            sel_q   <= '0;
        end else if (accept) begin
            burst_q <= (req_beats != CNTW'(1));
            we_q    <= req_write;
            sel_q   <= req_sel;
        end
    end

    // Raise the one-cycle completion and fault pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            done_q  <= resp_ack && last;
            fault_q <= resp_err;
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign beat_ack  = resp_ack;
    assign rd_data   = (in_bus && !we_q) ? wb_dat_i : '0;
    assign done_o    = done_q;
    assign fault_o   = fault_q;

    assign wb_cyc_o  = in_bus;
    assign wb_stb_o  = in_bus;
    assign wb_adr_o  = in_bus ? cur_addr : '0;
    assign wb_we_o   = in_bus && we_q;
    assign wb_sel_o  = in_bus ? sel_q : '0;
    assign wb_dat_o  = (in_bus && we_q) ? wr_data : '0;
    assign wb_cti_o  = cti;
    assign wb_bte_o  = 2'b00;
    assign wb_lock_o = 1'b0;

    // A refused beat closes the cycle and frees no request slot.
    assert_rty_drops_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        resp_rty |=> (!wb_cyc_o && !wb_stb_o && !req_ready));

    // The backoff keeps the beat position and the owed count.
    assert_rty_keeps_position_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_rty |=> (cur_addr == $past(cur_addr) && remaining == $past(remaining)));

    // An error aborts with a fault and never reports completion.
    assert_err_aborts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |=> (!wb_cyc_o && fault_o && !done_o));

    // A non-final burst beat keeps the cycle and steps the address.
    assert_burst_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_ack && wb_cti_o == CTI_INCR) |=>
            (wb_cyc_o && wb_adr_o == $past(wb_adr_o) + STEP_V));

    // The final acknowledge closes the cycle and reports completion.
    assert_final_ack_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_ack && wb_cti_o != CTI_INCR) |=> (!wb_cyc_o && done_o && !fault_o));

endmodule

// File: tb/tb_wbm_retry_port.sv
`timescale 1ns/1ps
// Bench for the retrying WISHBONE master: a table of transactions driven
// against a scripted slave, then directed reset checks.
module tb_wbm_retry_port;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 7;
    localparam int W  = 16;           // default backoff expected (R11)
    localparam int NV = 10;

    typedef struct packed {
        logic [6:0]  beats;
        logic        wr;
        logic [7:0]  rty_at;          // 8'hFF = no retry
        logic [7:0]  err_at;          // 8'hFF = no error
        logic [31:0] addr;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{7'd1,  1'b1, 8'hFF, 8'hFF, 32'h0000_1000},
        '{7'd1,  1'b0, 8'd0,  8'hFF, 32'h0000_1104},
        '{7'd4,  1'b1, 8'hFF, 8'hFF, 32'h0000_2000},
        '{7'd8,  1'b0, 8'd3,  8'hFF, 32'h0000_3000},
        '{7'd4,  1'b1, 8'hFF, 8'd2,  32'h0000_4010},
        '{7'd16, 1'b0, 8'd15, 8'hFF, 32'h0000_5000},
        '{7'd1,  1'b0, 8'd0,  8'd0,  32'h0000_6000},
        '{7'd64, 1'b1, 8'd0,  8'hFF, 32'h0001_0000},
        '{7'd32, 1'b0, 8'hFF, 8'd0,  32'h0002_0000},
        '{7'd4,  1'b0, 8'd1,  8'hFF, 32'h0003_0040}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [AW-1:0]   req_addr = '0;
    logic [CW-1:0]   req_beats = '0;
    logic            req_write = 1'b0;
    logic [3:0]      req_sel = '0;
    logic [DW-1:0]   wr_data = '0;
    logic            beat_ack;
    logic [DW-1:0]   rd_data;
    logic            done_o, fault_o;
    logic [AW-1:0]   wb_adr_o;
    logic [DW-1:0]   wb_dat_o;
    logic [DW-1:0]   wb_dat_i = '0;
    logic            wb_we_o, wb_stb_o, wb_cyc_o, wb_lock_o;
    logic [3:0]      wb_sel_o;
    logic [2:0]      wb_cti_o;
    logic [1:0]      wb_bte_o;
    logic            wb_ack_i = 1'b0, wb_err_i = 1'b0, wb_rty_i = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    wbm_retry_port dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_beats(req_beats), .req_write(req_write), .req_sel(req_sel),
        .wr_data(wr_data), .beat_ack(beat_ack), .rd_data(rd_data),
        .done_o(done_o), .fault_o(fault_o),
        .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i),
        .wb_we_o(wb_we_o), .wb_sel_o(wb_sel_o), .wb_stb_o(wb_stb_o),
        .wb_cyc_o(wb_cyc_o), .wb_cti_o(wb_cti_o), .wb_bte_o(wb_bte_o),
        .wb_lock_o(wb_lock_o), .wb_ack_i(wb_ack_i), .wb_err_i(wb_err_i),
        .wb_rty_i(wb_rty_i)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 cyc", {31'd0, wb_cyc_o}, 32'd0);
        chk("R1 stb", {31'd0, wb_stb_o}, 32'd0);
        chk("R1 adr", wb_adr_o, 32'd0);
        chk("R1 cti", {29'd0, wb_cti_o}, 32'd0);
        chk("R1 ready", {31'd0, req_ready}, 32'd1);
        chk("R1 done/fault", {30'd0, done_o, fault_o}, 32'd0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            int i;
            bit retried;
            bit ended;
            logic [31:0] pat;
            logic [3:0] sel;
            sel = VECS[v].wr ? 4'hF : 4'h3;
            @(negedge clk);
            chk("R2 ready before request", {31'd0, req_ready}, 32'd1);
            req_valid = 1'b1;
            req_addr  = VECS[v].addr;
            req_beats = VECS[v].beats;
            req_write = VECS[v].wr;
            req_sel   = sel;
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            i = 0; retried = 1'b0; ended = 1'b0;
            while (!ended) begin
                bit e, r;
                logic [2:0] ecti;
                ecti = (VECS[v].beats == 7'd1) ? 3'b000 :
                       (i == int'(VECS[v].beats) - 1) ? 3'b111 : 3'b010;
                // R2/R4/R7: cycle open, address and code of beat i
                chk("R2 cyc&stb", {30'd0, wb_cyc_o, wb_stb_o}, 32'd3);
                chk("R2 ready low while busy", {31'd0, req_ready}, 32'd0);
                chk("R4 R7 address", wb_adr_o, VECS[v].addr + 32'(4 * i));
                chk("R4 R7 cti", {29'd0, wb_cti_o}, {29'd0, ecti});
                chk("R2 we", {31'd0, wb_we_o}, {31'd0, VECS[v].wr});
                chk("R2 sel", {28'd0, wb_sel_o}, {28'd0, sel});
                chk("R10 bte/lock", {29'd0, wb_bte_o, wb_lock_o}, 32'd0);
                pat = 32'hA500_0000 ^ (32'(v) << 16) ^ 32'(i);
                e = (i == int'(VECS[v].err_at));
                r = (i == int'(VECS[v].rty_at)) && !retried;
                wr_data  = pat;
                wb_dat_i = ~pat;
                wb_ack_i = 1'b1;          // R9: ack always offered with err/rty
                wb_rty_i = r | e;
                wb_err_i = e;
                #1;
                chk("R5 R9 beat_ack", {31'd0, beat_ack}, {31'd0, !(e || r)});
                if (VECS[v].wr)
                    chk("R5 write data", wb_dat_o, pat);
                else
                    chk("R5 read data", rd_data, ~pat);
                @(posedge clk);
                @(negedge clk);
                wb_ack_i = 1'b0; wb_rty_i = 1'b0; wb_err_i = 1'b0;
                if (e) begin
                    // R8/R9: error wins, aborts without retry
                    chk("R8 cyc low after error", {31'd0, wb_cyc_o}, 32'd0);
                    chk("R8 R9 fault pulse", {30'd0, fault_o, done_o}, 32'd2);
                    ended = 1'b1;
                end else if (r) begin
                    int low;
                    retried = 1'b1;
                    low = 0;
                    if (!wb_cyc_o && !wb_stb_o) low++;
                    chk("R6 ready low in backoff", {31'd0, req_ready}, 32'd0);
                    req_valid = 1'b1;       // R2: ignored while waiting
                    req_addr  = 32'hDEAD_0000;
                    req_beats = 7'd1;
                    for (int k = 1; k < W; k++) begin
                        @(negedge clk);
                        if (!wb_cyc_o && !wb_stb_o) low++;
                    end
                    req_valid = 1'b0;
                    chk("R6 R11 backoff length", 32'(low), 32'(W));
                    @(negedge clk);
                end else begin
                    i++;
                    if (i == int'(VECS[v].beats)) begin
                        chk("R3 R4 done pulse", {30'd0, done_o, fault_o}, 32'd2);
                        chk("R3 cyc low after last", {31'd0, wb_cyc_o}, 32'd0);
                        ended = 1'b1;
                    end
                end
            end
            @(negedge clk);
            chk("R3 R8 pulses last one cycle", {30'd0, done_o, fault_o}, 32'd0);
            chk("R2 ready after end", {31'd0, req_ready}, 32'd1);
            chk("R1 cyc idle", {31'd0, wb_cyc_o}, 32'd0);
        end

        // R1: reset in the middle of a burst clears the bus
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0000_7000; req_beats = 7'd8;
        req_write = 1'b1; req_sel = 4'hF;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wb_ack_i = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R4 address after two beats", wb_adr_o, 32'h0000_7008);
        wb_ack_i = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 cyc after reset", {31'd0, wb_cyc_o}, 32'd0);
        chk("R1 adr after reset", wb_adr_o, 32'd0);
        chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule